// File: doc/BRIEF.md
# Host Cycle Interrupt Aggregator

This block merges the interrupt sources of a host-bus slave peripheral into one interrupt line toward the local CPU. There are six sources. Three are single-cycle pulses that mark an accepted host I/O cycle, TPM cycle or firmware cycle. The other three are requests from a BT mailbox and from two virtual UART queues. Each UART request also carries a 2-bit reason code. A source that is armed latches a sticky flag on the rising edge of its event. The flag stays set until the CPU clears it by writing a one to its bit. A master enable then gates the OR of all flags onto the output.

The CPU uses a small register-style interface. One write port loads the enable word. A second write port takes a write-one-to-clear mask aimed at the status word. The status word can be read at all times. The enable word and the status word use the same bit positions for the same source:

| Bit | Enable word | Status word |
|-----|-------------|-------------|
| 0 | master enable | gated summary |
| 1 | UART1 | UART1 flag |
| 2 | UART2 | UART2 flag |
| 3 | BT mailbox | BT mailbox flag |
| 4 | firmware cycle | firmware cycle flag |
| 5 | TPM cycle | TPM cycle flag |
| 6 | I/O cycle | I/O cycle flag |

Bit 7 of the status word is always zero. Bits 9:8 hold the UART1 reason and bits 11:10 hold the UART2 reason.

Top module: `host_irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, all enable bits are 0, `status` reads 0 and `cpu_irq` is low.
- R2: When a source's enable bit is 1, a low-to-high transition on its event input sets that source's status flag on the same clock edge that samples the event high. The positions are: UART1 bit 1, UART2 bit 2, BT bit 3, firmware bit 4, TPM bit 5, I/O bit 6. The enable word uses the same positions, with bit 0 as the master enable.
- R3: When a source's enable bit is 0, its rising edge is ignored. Setting the enable later, while the event input stays high, does not set the flag.
- R4: An event input held high sets its flag once only. After the flag is cleared, the flag stays clear until the input falls and rises again.
- R5: A clear write of `clr_mask` with bit n set clears status flag n. Flags whose mask bit is 0 are unchanged.
- R6: When an accepted rising edge and a clear of the same flag happen in the same cycle, the flag ends up set.
- R7: `cpu_irq` and status bit 0 both equal the master enable ANDed with the OR of the six source flags.
- R8: Flags latch while the master enable is 0. Turning the master enable on later raises `cpu_irq` in the cycle after the write edge.
- R9: On an accepted UART edge, that UART's reason field captures the code present at its input (1 = queue threshold, 2 = queue timeout, 0 = undefined). The UART1 reason is status bits 9:8 and the UART2 reason is bits 11:10. A later accepted edge overwrites the code.
- R10: A reason field reads 0 whenever its UART flag is clear. The field clears on the same edge as the flag.
- R11: Writing 1 to clear-mask bit 0 or bit 7 has no effect, and status bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Load the enable word this cycle |
| en_wdata | input | 7 | Enable word (bit 0 master, bits 6:1 per source) |
| clr_wr | input | 1 | Apply the clear mask this cycle |
| clr_mask | input | 12 | Write-one-to-clear mask, aligned with the status word |
| io_evt | input | 1 | Accepted host I/O cycle pulse |
| tpm_evt | input | 1 | Accepted host TPM cycle pulse |
| fw_evt | input | 1 | Accepted host firmware cycle pulse |
| bt_req | input | 1 | BT mailbox interrupt request |
| u1_req | input | 1 | UART1 queue interrupt request |
| u1_code | input | 2 | UART1 reason code |
| u2_req | input | 1 | UART2 queue interrupt request |
| u2_code | input | 2 | UART2 reason code |
| status | output | 12 | Sticky flags, gated summary and UART reasons |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The bench targets these corner cases:

- **Event held high across a clear.** A design that acts on the level rather than the edge would set the flag again at once.
- **Set and clear of the same flag in one cycle.** If clear wins, the design loses an interrupt.
- **Enable turned on while an event is already high.** A design that samples the edge without checking the enable would raise a false interrupt.
- **Flags that collect while the master enable is off.** The design must keep the line low and then assert it as soon as the master enable is turned on.
- **Reason fields.** The bench checks that each reason field is zero whenever its flag is clear. A design that holds a stale code, or that clears the wrong UART's code, shows up in the compare on every clock.

// File: rtl/hirq_pkg.sv
// Package: shared sizes and source indices for the host interrupt aggregator.
// Assumes the status word layout documented in the block brief.
package hirq_pkg;
    localparam int NSRC     = 6;              // number of interrupt sources
    localparam int NUART    = 2;              // sources that carry a reason code
    localparam int REASON_W = 2;              // width of one reason code
    localparam int EN_W     = NSRC + 1;       // master bit plus one per source
    localparam int STAT_W   = 8 + NUART * REASON_W;

    // Index of each source inside the source vector (status bit = index + 1)
    typedef enum logic [2:0] {
        SRC_UART1 = 3'd0,
        SRC_UART2 = 3'd1,
        SRC_BT    = 3'd2,
        SRC_FW    = 3'd3,
        SRC_TPM   = 3'd4,
        SRC_IO    = 3'd5
    } src_idx_e;

    typedef logic [REASON_W-1:0] reason_t;
endpackage

// File: rtl/hirq_cfg_reg.sv
// Module: enable word register.
// Holds the master and per-source enables. It loads the whole word on a
// write strobe and resets to zero.
module hirq_cfg_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q
);
    // Load the enable word on a write; clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (wr) en_q <= wdata;
    end
endmodule

// File: rtl/hirq_src_cell.sv
// Module: one interrupt source with edge detect and a sticky flag.
// Assumes that evt is synchronous to clk. A rising edge seen while arm is
// high sets the flag. A clear removes the flag unless an accepted edge
// arrives in the same cycle, in which case the set wins. The history
// register resets to 0, so an event that is already high when reset ends
// counts as an edge.
module hirq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic arm,
    input  logic clr,
    output logic flag,
    output logic accept
);
    logic prev_q;

    assign accept = evt && !prev_q && arm;

    // Track the previous event level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= evt;
    end

    // Sticky flag: set on an accepted edge, otherwise clear on request
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (accept) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // R2: an armed rising edge leaves the flag set on the next cycle
    p_set_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt) && arm) |=> flag);
    // R5: a flag with no clear request holds its value
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R5: a clear with the event low removes the flag
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag);
    // R3: an unarmed source never raises a clear flag
    p_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !arm) |=> !flag);
endmodule

// File: rtl/hirq_reason_cell.sv
// Module: captures a UART reason code next to that UART's flag.
// Assumes that accept and clr come from the matching source cell. The code
// is captured on every accepted edge and is zeroed by a clear that the set
// does not override, so the field reads zero whenever the flag is clear.
module hirq_reason_cell #(
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          clr,
    input  logic [RW-1:0] code,
    input  logic          flag,
    output logic [RW-1:0] reason
);
    // Capture the code on an accepted edge; zero it together with the flag
    always_ff @(posedge clk) begin
        if (!rst_n)      reason <= '0;
        else if (accept) reason <= code;
        else if (clr)    reason <= '0;
    end

    // R10: the reason field is zero whenever its flag is clear
    p_reason_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> (reason == '0));
    // R9: an accepted edge records the code that was presented
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (reason == $past(code)));
endmodule

// File: rtl/host_irq_aggregator.sv
// Module: top of the host cycle interrupt aggregator.
// Combines six sticky source flags into one CPU interrupt, gated by a master
// enable. It also builds the status word {u2 reason, u1 reason, 0, flags,
// summary}. Assumes that all inputs are synchronous to clk.
module host_irq_aggregator
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_wdata,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic              io_evt,
    input  logic              tpm_evt,
    input  logic              fw_evt,
    input  logic              bt_req,
    input  logic              u1_req,
    input  logic [1:0]        u1_code,
    input  logic              u2_req,
    input  logic [1:0]        u2_code,
    output logic [STAT_W-1:0] status,
    output logic              cpu_irq
);
    logic [EN_W-1:0] en_q;
    logic [NSRC-1:0] evt_vec;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] accepts;
    logic [NSRC-1:0] clrs;
    reason_t         codes   [NUART];
    reason_t         reasons [NUART];
    logic            any_flag;

    // Order the event inputs by source index
    always_comb begin
        evt_vec           = '0;
        evt_vec[SRC_UART1] = u1_req;
        evt_vec[SRC_UART2] = u2_req;
        evt_vec[SRC_BT]    = bt_req;
        evt_vec[SRC_FW]    = fw_evt;
        evt_vec[SRC_TPM]   = tpm_evt;
        evt_vec[SRC_IO]    = io_evt;
    end

    assign codes[0] = u1_code;
    assign codes[1] = u2_code;

    hirq_cfg_reg #(.W(EN_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .en_q  (en_q)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign clrs[k] = clr_wr && clr_mask[k+1];
        hirq_src_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_vec[k]),
            .arm    (en_q[k+1]),
            .clr    (clrs[k]),
            .flag   (flags[k]),
            .accept (accepts[k])
        );
    end

    for (genvar u = 0; u < NUART; u++) begin : g_reason
        hirq_reason_cell #(.RW(REASON_W)) u_rsn (
            .clk    (clk),
            .rst_n  (rst_n),
            .accept (accepts[u]),
            .clr    (clrs[u]),
            .code   (codes[u]),
            .flag   (flags[u]),
            .reason (reasons[u])
        );
    end

    // Gate the OR of all flags with the master enable
    always_comb begin
        any_flag = |flags;
        cpu_irq  = en_q[0] && any_flag;
    end

    // Assemble the status word
    always_comb begin
        status        = '0;
        status[0]     = cpu_irq;
        status[NSRC:1] = flags;
        for (int u = 0; u < NUART; u++)
            status[8 + u*REASON_W +: REASON_W] = reasons[u];
    end

    // R7: the master enable off forces the line low
    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[0] |-> !cpu_irq);
    // R7: no flag set means no interrupt
    p_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !cpu_irq);
    // R8: the master enable turned on with a flag pending raises the line
    p_late_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en_q[0]) && any_flag) |-> cpu_irq);
    // R11: status bit 7 is always zero
    p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7]);
endmodule

// File: tb/tb_host_irq_aggregator.sv
module tb_host_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0;
    logic [6:0]  en_wdata = '0;
    logic        clr_wr = 1'b0;
    logic [11:0] clr_mask = '0;
    logic        io_evt = 1'b0, tpm_evt = 1'b0, fw_evt = 1'b0, bt_req = 1'b0;
    logic        u1_req = 1'b0, u2_req = 1'b0;
    logic [1:0]  u1_code = '0, u2_code = '0;
    logic [11:0] status;
    logic        cpu_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    // Reference model state
    bit [6:0] m_en;
    bit [6:0] m_flag;   // index 1..6 used
    bit [6:0] m_prev;
    int       m_rsn [2];

    always #2.5 clk = ~clk;   // 200 MHz

    host_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .io_evt(io_evt),
        .tpm_evt(tpm_evt), .fw_evt(fw_evt), .bt_req(bt_req),
        .u1_req(u1_req), .u1_code(u1_code), .u2_req(u2_req),
        .u2_code(u2_code), .status(status), .cpu_irq(cpu_irq)
    );

    function automatic bit [6:0] ev_now();
        return {io_evt, tpm_evt, fw_evt, bt_req, u2_req, u1_req, 1'b0};
    endfunction

    function automatic bit m_irq();
        return m_en[0] && (m_flag[6:1] != 0);
    endfunction

    function automatic bit [11:0] m_status();
        bit [11:0] s;
        s = '0;
        s[0] = m_irq();
        s[6:1] = m_flag[6:1];
        s[9:8] = 2'(m_rsn[0]);
        s[11:10] = 2'(m_rsn[1]);
        return s;
    endfunction

    // Behavioural model update at each rising edge
    always @(posedge clk) begin
        bit [6:0] ev;
        ev = ev_now();
        started = 1;
        if (!rst_n) begin
            m_en = '0; m_flag = '0; m_prev = '0; m_rsn[0] = 0; m_rsn[1] = 0;
        end else begin
            for (int s = 1; s <= 6; s++) begin
                bit acc, clr;
                acc = ev[s] && !m_prev[s] && m_en[s];
                clr = clr_wr && clr_mask[s];
                if (acc) begin
                    m_flag[s] = 1;
                    if (s == 1) m_rsn[0] = int'(u1_code);
                    if (s == 2) m_rsn[1] = int'(u2_code);
                end else if (clr) begin
                    m_flag[s] = 0;
                    if (s <= 2) m_rsn[s-1] = 0;
                end
            end
            m_prev = ev;
            if (en_wr) m_en = en_wdata;
        end
    end

    // Compare the model with the design on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            bit [11:0] e;
            e = m_status();
            n_cmp++;
            if (status !== e || cpu_irq !== m_irq()) begin
                n_bad++;
                if (cpu_irq !== m_irq() || status[0] !== e[0])
                    $display("FAIL R7 irq: status=%h irq=%b expected status=%h irq=%b",
                             status, cpu_irq, e, m_irq());
                else if (status[6:1] !== e[6:1])
                    $display("FAIL R2 flags: actual=%h expected=%h", status, e);
                else if (status[11:8] !== e[11:8])
                    $display("FAIL R9 reasons: actual=%h expected=%h", status, e);
                else
                    $display("FAIL R11 status: actual=%h expected=%h", status, e);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_en(logic [6:0] v);
        en_wr = 1; en_wdata = v; step(); en_wr = 0;
    endtask

    task automatic clear(logic [11:0] m);
        clr_wr = 1; clr_mask = m; step(); clr_wr = 0; clr_mask = '0;
    endtask

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 reset status", status, 12'h000);
        chk("R1 reset irq", {11'b0, cpu_irq}, 12'h000);

        // R3: events with every enable still 0 after reset
        {io_evt, tpm_evt, fw_evt, bt_req, u1_req, u2_req} = '1;
        step();
        {io_evt, tpm_evt, fw_evt, bt_req, u1_req, u2_req} = '0;
        step();
        chk("R3 disabled edges ignored", status, 12'h000);

        set_en(7'h7F);
        io_evt = 1; step(); io_evt = 0;
        chk("R2 io flag bit6, R7 summary", status, 12'h041);
        step();
        clear(12'h040);
        chk("R5 io cleared", status, 12'h000);

        // R9: reason capture for both UARTs
        u1_req = 1; u1_code = 2; step(); u1_req = 0;
        chk("R9 u1 timeout reason", status, 12'h203);
        u2_req = 1; u2_code = 1; step(); u2_req = 0;
        chk("R9 u2 threshold reason", status, 12'h607);
        clear(12'h002);
        chk("R5 R10 u1 clear keeps u2", status, 12'h405);
        clear(12'h004);
        chk("R10 u2 reason cleared", status, 12'h000);

        // R4: held-high event, cleared while still high
        tpm_evt = 1; step();
        chk("R4 tpm set", status, 12'h021);
        step(); step();
        clear(12'h020);
        step();
        chk("R4 held level does not reset flag", status, 12'h000);
        tpm_evt = 0; step();

        // R6: set and clear in the same cycle
        fw_evt = 1; clr_wr = 1; clr_mask = 12'h010; step();
        clr_wr = 0; clr_mask = '0; fw_evt = 0;
        chk("R6 set wins", status, 12'h011);
        clear(12'h010);

        // R8: flags latch with the master enable off
        set_en(7'h7E);
        bt_req = 1; step(); bt_req = 0;
        chk("R8 bt latched, R7 gated", status, 12'h008);
        chk("R7 irq low when gated", {11'b0, cpu_irq}, 12'h000);
        set_en(7'h7F);
        chk("R8 irq after enable", {11'b0, cpu_irq}, 12'h001);

        // R11: clearing bit 0 and bit 7 has no effect
        clear(12'h081);
        chk("R11 bit0 clear ignored", status, 12'h009);
        clear(12'h008);

        // R3: enabling while the event level is already high
        set_en(7'h77);
        bt_req = 1; step();
        set_en(7'h7F);
        step();
        chk("R3 late enable no set", status, 12'h000);
        bt_req = 0; step();

        // Random traffic, compared every clock against the model
        for (int i = 0; i < 2000; i++) begin
            {io_evt, tpm_evt, fw_evt, bt_req, u1_req, u2_req} = 6'($urandom);
            u1_code = 2'($urandom); u2_code = 2'($urandom);
            en_wr = ($urandom % 16) == 0;
            en_wdata = 7'($urandom);
            clr_wr = ($urandom % 3) == 0;
            clr_mask = 12'($urandom);
            step();
        end
        en_wr = 0; clr_wr = 0;
        step();
        summary();
    end
endmodule